// File: doc/BRIEF.md
# Flash Memory Write Controller

This block sits in front of a small behavioural flash array and lets a bus master program it through a handful of memory-mapped registers. The master enables writing, sets a word address, moves that address into an internal write pointer, supplies a data word, and issues a command. The command can program one word, program a word and then advance the pointer, or erase the whole page that holds the pointer. Every program or erase holds a busy flag for a fixed number of clock cycles, set by a parameter. The array changes at the end of that busy window.

The array models real flash rules. An erase sets every word of a page to all ones. A program can only clear bits, so the stored word becomes the old word ANDed with the new data. After an erase, a third program to the same word raises a sticky error flag. The last page of the array is the lock page. Each page owns one bit in it: page p uses lock-page word p/32, bit p%32. A page whose bit reads 0 silently drops program and erase commands. The lock page's own bit also protects the lock page, except while the debug-mode input is high.

The sequencer has three states: ST_IDLE, ST_PROG and ST_ERASE. From ST_IDLE, an accepted erase command moves to ST_ERASE, and an accepted write-once or write-trigger command moves to ST_PROG. A command is accepted when write enable is set and the pointer's page is not locked. Both busy states return to ST_IDLE when the busy timer reaches zero, which is also the cycle the array is updated. If one command write sets several operation bits, erase wins over trigger, trigger over write-once, and write-once over load-address.

Top module: `flashctl_top`

## Requirements
- R1: While CTRL bit 0 (write enable) is 0, the load-address, write-once, write-trigger and erase commands have no effect.
- R2: Writing CMD with bit 0 (load-address) set copies the ADDR register (a word index) into the write pointer, readable at register 6. An ADDR value at or above the total word count leaves the pointer unchanged.
- R3: An accepted program or erase holds STATUS bit 0 (busy) high for exactly BUSY_CYCLES clock cycles, starting the cycle after the command write.
- R4: STATUS bit 1 (data ready) is 1 after reset. It goes to 0 when WDATA is written, and back to 1 when a program command is accepted.
- R5: CMD bit 2 (write-trigger) programs the word at the pointer and then advances the pointer by one. Past the last word of a page, the pointer wraps to word 0 of the same page. CMD bit 1 (write-once) leaves the pointer unchanged.
- R6: A program leaves the stored word equal to the old word ANDed with the WDATA value captured when the command was accepted.
- R7: CMD bit 3 (erase) sets every word of the pointer's page to 0xFFFFFFFF and resets the program counts of those words.
- R8: A program or erase aimed at a page whose lock bit is 0 is dropped: busy stays 0, the array is unchanged, and data ready is unchanged.
- R9: The lock page (the last page) is protected by its own lock bit, number NUM_PAGES. That protection does not apply while dbg_mode is 1.
- R10: A third program to the same word since the last erase sets STATUS bit 2 (over-program error), and that bit stays set.
- R11: A command write with any of bits 0 to 3 set while busy is ignored and sets STATUS bit 3 (command error).
- R12: CMD bit 4 (clear) clears both error bits, unless the same write is ignored for being issued while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | Debug mode; lifts the lock page's self-protection |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index: 0 CTRL, 1 ADDR, 2 CMD, 3 WDATA, 4 STATUS, 5 PEEK (array word at ADDR), 6 write pointer |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |

## Verification
The assertions check on every cycle that the busy timer counts down one step per cycle and returns the sequencer to idle, and that a committed program stores the AND of the old word and the captured data. They also check that an erase fills the page with ones, that trigger increments stay inside their page, that commands are refused when write enable is off, the page is locked, or the sequencer is busy, and that the data-ready and error flags respond to their causes. Some behaviour only the bench scenarios can show, because it spans many commands: the over-program count across three programs and its reset by erase, the lock bit of one page taking effect after it is programmed, and the lock page becoming erasable only in debug mode. The bench's reference model confirms all of this at the register port.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } fc_state_e;

    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_ADDR   = 3'd1;
    localparam logic [2:0] RA_CMD    = 3'd2;
    localparam logic [2:0] RA_WDATA  = 3'd3;
    localparam logic [2:0] RA_STATUS = 3'd4;
    localparam logic [2:0] RA_PEEK   = 3'd5;
    localparam logic [2:0] RA_WPTR   = 3'd6;

    localparam int CB_LOAD  = 0;
    localparam int CB_ONCE  = 1;
    localparam int CB_TRIG  = 2;
    localparam int CB_ERASE = 3;
    localparam int CB_CLR   = 4;
    localparam int CMD_W    = 5;

    typedef struct packed {
        logic cmd_err;
        logic over_err;
        logic ready;
        logic busy;
    } fc_status_t;

endpackage

// File: rtl/flashctl_regs.sv
module flashctl_regs
    import flashctl_pkg::*;
#(
    parameter int TOTAL_WORDS = 40,
    parameter int AW          = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wr_en,
    output logic [31:0]       addr_q,
    output logic [31:0]       wdata_q,
    output logic              cmd_wr,
    output logic [CMD_W-1:0]  cmd_bits,
    input  logic              prog_accept,
    input  logic              busy,
    input  logic              over_err,
    input  logic              cmd_err,
    input  logic [31:0]       peek_data,
    input  logic [AW-1:0]     wptr,
    output logic [AW-1:0]     peek_addr
);

    logic       ready_q;
    logic       peek_ok;
    fc_status_t status;

    assign cmd_wr    = bus_we && (bus_addr == RA_CMD);
    assign cmd_bits  = bus_wdata[CMD_W-1:0];
    assign peek_ok   = addr_q < 32'(TOTAL_WORDS);
    assign peek_addr = addr_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == RA_CTRL)  wr_en   <= bus_wdata[0];
            if (bus_addr == RA_ADDR)  addr_q  <= bus_wdata;
            if (bus_addr == RA_WDATA) wdata_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b1;
        end else if (bus_we && (bus_addr == RA_WDATA)) begin
            ready_q <= 1'b0;
        end else if (prog_accept) begin
            ready_q <= 1'b1;
        end
    end

    always_comb begin
        status.busy     = busy;
        status.ready    = ready_q;
        status.over_err = over_err;
        status.cmd_err  = cmd_err;
    end

    always_comb begin
        unique case (bus_addr)
            RA_CTRL:   bus_rdata = {31'd0, wr_en};
            RA_ADDR:   bus_rdata = addr_q;
            RA_WDATA:  bus_rdata = wdata_q;
            RA_STATUS: bus_rdata = {28'd0, status};
            RA_PEEK:   bus_rdata = peek_ok ? peek_data : 32'd0;
            RA_WPTR:   bus_rdata = 32'(wptr);
            default:   bus_rdata = 32'd0;
        endcase
    end

    a_r4_wdata_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == RA_WDATA) |=> !ready_q);

    a_r4_accept_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        prog_accept |=> ready_q);

endmodule

// File: rtl/flashctl_array.sv
module flashctl_array #(
    parameter int WORDS_PER_PAGE = 8,
    parameter int NUM_PAGES      = 4,
    parameter int AW             = 6,
    parameter int PG_W           = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_mode,
    input  logic            commit_prog,
    input  logic            commit_erase,
    input  logic [AW-1:0]   c_addr,
    input  logic [31:0]     c_data,
    input  logic [PG_W-1:0] q_page,
    output logic            q_locked,
    input  logic [AW-1:0]   peek_addr,
    output logic [31:0]     peek_data,
    output logic            over_hit
);

    localparam int OFF_W       = AW - PG_W;
    localparam int TOTAL_WORDS = (NUM_PAGES + 1) * WORDS_PER_PAGE;
    localparam int LOCK_BASE   = NUM_PAGES * WORDS_PER_PAGE;

    logic [31:0]     mem [TOTAL_WORDS];
    logic [1:0]      cnt [TOTAL_WORDS];
    logic [AW-1:0]   lock_idx;
    logic [31:0]     lock_word;
    logic            lock_bit;
    logic            self_page;
    logic [PG_W-1:0] e_page;
    logic [31:0]     cur_word;
    logic [AW-1:0]   e_first;

    assign e_page   = c_addr[AW-1:OFF_W];
    assign e_first  = {e_page, {OFF_W{1'b0}}};
    assign cur_word = mem[c_addr];

    always_comb begin
        lock_idx  = AW'(LOCK_BASE) + AW'(q_page >> 5);
        lock_word = mem[lock_idx];
        lock_bit  = lock_word[5'(q_page)];
        self_page = (q_page == PG_W'(NUM_PAGES));
        q_locked  = !lock_bit && !(self_page && dbg_mode);
    end

    assign peek_data = mem[peek_addr];
    assign over_hit  = commit_prog && (cnt[c_addr] == 2'd2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL_WORDS; i++) begin
                mem[i] <= '1;
                cnt[i] <= 2'd0;
            end
        end else if (commit_erase) begin
            for (int i = 0; i < WORDS_PER_PAGE; i++) begin
                mem[{e_page, OFF_W'(i)}] <= '1;
                cnt[{e_page, OFF_W'(i)}] <= 2'd0;
            end
        end else if (commit_prog) begin
            mem[c_addr] <= mem[c_addr] & c_data;
            if (cnt[c_addr] != 2'd3) cnt[c_addr] <= cnt[c_addr] + 2'd1;
        end
    end

    a_r6_program_ands: assert property (@(posedge clk) disable iff (!rst_n)
        commit_prog |=> mem[$past(c_addr)] == ($past(cur_word) & $past(c_data)));

    a_r7_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        commit_erase |=> mem[$past(e_first)] == 32'hFFFF_FFFF);

endmodule

// File: rtl/flashctl_seq.sv
module flashctl_seq
    import flashctl_pkg::*;
#(
    parameter int WORDS_PER_PAGE = 8,
    parameter int NUM_PAGES      = 4,
    parameter int BUSY_CYCLES    = 4000,
    parameter int AW             = 6,
    parameter int PG_W           = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      addr_q,
    input  logic [31:0]      wdata_q,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_bits,
    input  logic             page_locked,
    input  logic             over_hit,
    output logic [AW-1:0]    wptr,
    output logic             busy,
    output logic             cmd_err,
    output logic             over_err,
    output logic             prog_accept,
    output logic             commit_prog,
    output logic             commit_erase,
    output logic [AW-1:0]    c_addr,
    output logic [31:0]      c_data
);

    localparam int OFF_W       = AW - PG_W;
    localparam int TOTAL_WORDS = (NUM_PAGES + 1) * WORDS_PER_PAGE;
    localparam int TW          = $clog2(BUSY_CYCLES + 1);

    fc_state_e     state, state_nx;
    logic [TW-1:0] timer;
    logic          op_inc;
    logic          op_any;
    logic          go_ok;
    logic          start;
    logic          load_go;
    logic          clr_go;
    logic          timer_zero;

    assign op_any     = cmd_wr && (|cmd_bits[CB_ERASE:CB_LOAD]);
    assign go_ok      = (state == ST_IDLE) && cmd_wr && wr_en;
    assign timer_zero = (timer == '0);
    assign start      = go_ok && !page_locked &&
                        (cmd_bits[CB_ERASE] || cmd_bits[CB_TRIG] || cmd_bits[CB_ONCE]);
    assign load_go    = go_ok && cmd_bits[CB_LOAD] && !cmd_bits[CB_ERASE] &&
                        !cmd_bits[CB_TRIG] && !cmd_bits[CB_ONCE] &&
                        (addr_q < 32'(TOTAL_WORDS));
    assign clr_go     = cmd_wr && cmd_bits[CB_CLR] && !(busy && op_any);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_ok && !page_locked) begin
                    if (cmd_bits[CB_ERASE])
                        state_nx = ST_ERASE;
                    else if (cmd_bits[CB_TRIG] || cmd_bits[CB_ONCE])
                        state_nx = ST_PROG;
                end
            end
            ST_PROG:  if (timer_zero) state_nx = ST_IDLE;
            ST_ERASE: if (timer_zero) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        commit_prog  = (state == ST_PROG)  && timer_zero;
        commit_erase = (state == ST_ERASE) && timer_zero;
        prog_accept  = start && !cmd_bits[CB_ERASE];
    end

    // busy timer and captured operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer  <= '0;
            c_addr <= '0;
            c_data <= '0;
            op_inc <= 1'b0;
        end else if (start) begin
            timer  <= TW'(BUSY_CYCLES - 1);
            c_addr <= wptr;
            c_data <= wdata_q;
            op_inc <= !cmd_bits[CB_ERASE] && cmd_bits[CB_TRIG];
        end else if (busy && !timer_zero) begin
            timer <= timer - 1'b1;
        end
    end

    // write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (load_go) begin
            wptr <= addr_q[AW-1:0];
        end else if (commit_prog && op_inc) begin
            wptr <= {c_addr[AW-1:OFF_W], c_addr[OFF_W-1:0] + OFF_W'(1)};
        end
    end

    // sticky error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err  <= 1'b0;
            over_err <= 1'b0;
        end else begin
            cmd_err  <= (cmd_err  && !clr_go) || (busy && op_any);
            over_err <= (over_err && !clr_go) || over_hit;
        end
    end

    a_r3_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !timer_zero) |=> (busy && timer == $past(timer) - 1'b1));

    a_r3_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && timer_zero) |=> !busy);

    a_r1_we_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_wr && !wr_en) |=> (state == ST_IDLE && $stable(wptr)));

    a_r8_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_wr && page_locked) |=> state == ST_IDLE);

    a_r5_wrap_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_prog && op_inc) |=> wptr[AW-1:OFF_W] == $past(c_addr[AW-1:OFF_W]));

    a_r11_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_any) |=> (cmd_err && $stable(c_addr)));

    a_r10_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        over_hit |=> over_err);

endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
    import flashctl_pkg::*;
#(
    parameter int WORDS_PER_PAGE = 8,
    parameter int NUM_PAGES      = 4,
    parameter int BUSY_CYCLES    = 4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_mode,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    localparam int TOTAL_WORDS = (NUM_PAGES + 1) * WORDS_PER_PAGE;
    localparam int OFF_W       = $clog2(WORDS_PER_PAGE);
    localparam int PG_W        = $clog2(NUM_PAGES + 1);
    localparam int AW          = OFF_W + PG_W;

    logic             wr_en;
    logic [31:0]      addr_q;
    logic [31:0]      wdata_q;
    logic             cmd_wr;
    logic [CMD_W-1:0] cmd_bits;
    logic             prog_accept;
    logic             busy;
    logic             over_err;
    logic             cmd_err;
    logic [31:0]      peek_data;
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    peek_addr;
    logic             page_locked;
    logic             over_hit;
    logic             commit_prog;
    logic             commit_erase;
    logic [AW-1:0]    c_addr;
    logic [31:0]      c_data;

    flashctl_regs #(
        .TOTAL_WORDS(TOTAL_WORDS),
        .AW         (AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wr_en      (wr_en),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .cmd_wr     (cmd_wr),
        .cmd_bits   (cmd_bits),
        .prog_accept(prog_accept),
        .busy       (busy),
        .over_err   (over_err),
        .cmd_err    (cmd_err),
        .peek_data  (peek_data),
        .wptr       (wptr),
        .peek_addr  (peek_addr)
    );

    flashctl_seq #(
        .WORDS_PER_PAGE(WORDS_PER_PAGE),
        .NUM_PAGES     (NUM_PAGES),
        .BUSY_CYCLES   (BUSY_CYCLES),
        .AW            (AW),
        .PG_W          (PG_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .cmd_wr      (cmd_wr),
        .cmd_bits    (cmd_bits),
        .page_locked (page_locked),
        .over_hit    (over_hit),
        .wptr        (wptr),
        .busy        (busy),
        .cmd_err     (cmd_err),
        .over_err    (over_err),
        .prog_accept (prog_accept),
        .commit_prog (commit_prog),
        .commit_erase(commit_erase),
        .c_addr      (c_addr),
        .c_data      (c_data)
    );

    flashctl_array #(
        .WORDS_PER_PAGE(WORDS_PER_PAGE),
        .NUM_PAGES     (NUM_PAGES),
        .AW            (AW),
        .PG_W          (PG_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .dbg_mode    (dbg_mode),
        .commit_prog (commit_prog),
        .commit_erase(commit_erase),
        .c_addr      (c_addr),
        .c_data      (c_data),
        .q_page      (wptr[AW-1:OFF_W]),
        .q_locked    (page_locked),
        .peek_addr   (peek_addr),
        .peek_data   (peek_data),
        .over_hit    (over_hit)
    );

endmodule

// File: tb/flashctl_top_tb_top.sv
`timescale 1ns/100ps
module flashctl_top_tb_top;

    localparam int WPP   = 8;
    localparam int NP    = 4;
    localparam int BUSYC = 5;
    localparam int TOTAL = (NP + 1) * WPP;
    localparam int LBASE = NP * WPP;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    flashctl_top #(.WORDS_PER_PAGE(WPP), .NUM_PAGES(NP), .BUSY_CYCLES(BUSYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] mm [TOTAL];
    int          mc [TOTAL];
    bit          m_we, m_ready, m_oerr, m_cerr, m_busy, m_erase, m_inc;
    int          m_addr, m_wdata, m_wptr, m_timer, m_caddr, m_cdata;

    function automatic bit m_locked(int w);
        int pg = w / WPP;
        logic [31:0] lw = mm[LBASE + pg / 32];
        return (lw[pg % 32] == 1'b0) && !(pg == NP && dbg_mode);
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return {31'd0, m_we};
            3'd1: return m_addr;
            3'd3: return m_wdata;
            3'd4: return {28'd0, m_cerr, m_oerr, m_ready, m_busy};
            3'd5: return (m_addr >= 0 && m_addr < TOTAL) ? mm[m_addr] : 32'd0;
            3'd6: return m_wptr;
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_cmd(logic [4:0] c, bit was_busy);
        if (was_busy) begin
            if (c[3:0] != 4'd0) m_cerr = 1;
            else if (c[4]) begin m_cerr = 0; m_oerr = 0; end
        end else begin
            if (c[4]) begin m_cerr = 0; m_oerr = 0; end
            if (m_we) begin
                if (c[3]) begin
                    if (!m_locked(m_wptr)) begin
                        m_busy = 1; m_erase = 1; m_timer = BUSYC - 1; m_caddr = m_wptr;
                    end
                end else if (c[2] || c[1]) begin
                    if (!m_locked(m_wptr)) begin
                        m_busy = 1; m_erase = 0; m_inc = c[2]; m_timer = BUSYC - 1;
                        m_caddr = m_wptr; m_cdata = m_wdata; m_ready = 1;
                    end
                end else if (c[0] && m_addr >= 0 && m_addr < TOTAL) begin
                    m_wptr = m_addr;
                end
            end
        end
    endtask

    task automatic m_commit();
        if (m_erase) begin
            int base = (m_caddr / WPP) * WPP;
            for (int i = 0; i < WPP; i++) begin mm[base + i] = '1; mc[base + i] = 0; end
        end else begin
            if (mc[m_caddr] == 2) m_oerr = 1;
            if (mc[m_caddr] < 3) mc[m_caddr]++;
            mm[m_caddr] = mm[m_caddr] & m_cdata;
            if (m_inc) m_wptr = (m_caddr / WPP) * WPP + ((m_caddr % WPP) + 1) % WPP;
        end
    endtask

    always @(posedge clk) begin
        bit wb;
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) begin mm[i] = '1; mc[i] = 0; end
            m_we = 0; m_ready = 1; m_oerr = 0; m_cerr = 0; m_busy = 0;
            m_erase = 0; m_inc = 0; m_addr = 0; m_wdata = 0; m_wptr = 0;
            m_timer = 0; m_caddr = 0; m_cdata = 0;
        end else begin
            wb = m_busy;
            if (bus_we) begin
                case (bus_addr)
                    3'd0: m_we = bus_wdata[0];
                    3'd1: m_addr = bus_wdata;
                    3'd2: m_cmd(bus_wdata[4:0], wb);
                    3'd3: begin m_wdata = bus_wdata; m_ready = 0; end
                    default: ;
                endcase
            end
            if (wb) begin
                if (m_timer == 0) begin m_commit(); m_busy = 0; end
                else m_timer--;
            end
        end
        #1;
        if (rst_n) begin
            logic [31:0] e;
            string t;
            e = m_read(bus_addr);
            case (bus_addr)
                3'd4: t = "R3";
                3'd5: t = "R6";
                3'd6: t = "R5";
                default: t = "R2";
            endcase
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s model compare reg %0d: actual %08h expected %08h",
                         t, bus_addr, bus_rdata, e);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        bus_addr = 3'd4;
        #1;
        while (bus_rdata[0]) begin @(negedge clk); #1; end
    endtask

    task automatic peek(int w, logic [31:0] exp, string tag);
        wr(3'd1, w);
        rd_chk(3'd5, exp, tag);
    endtask

    task automatic program_at(int w, logic [31:0] d);
        wr(3'd1, w); wr(3'd2, 32'h1); wr(3'd3, d); wr(3'd2, 32'h2); wait_idle();
    endtask

    // ---------------- scenarios ----------------
    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(3'd4, 32'h2, "R4 reset status");
        rd_chk(3'd6, 32'h0, "R2 reset pointer");

        // R1: write enable off
        wr(3'd1, 3); wr(3'd2, 32'h1);
        rd_chk(3'd6, 32'h0, "R1 load ignored without enable");
        wr(3'd2, 32'h2);
        rd_chk(3'd4, 32'h2, "R1 program ignored without enable");

        // R2: load address
        wr(3'd0, 1);
        wr(3'd2, 32'h1);
        rd_chk(3'd6, 32'd3, "R2 load address");
        wr(3'd1, 40); wr(3'd2, 32'h1);
        rd_chk(3'd6, 32'd3, "R2 out of range load ignored");
        wr(3'd1, 3);

        // R4, R3, R6: single program
        wr(3'd3, 32'hF0F0_1234);
        rd_chk(3'd4, 32'h0, "R4 ready cleared by data write");
        wr(3'd2, 32'h2);
        bus_addr = 3'd4; #1; n = 0;
        while (bus_rdata[0]) begin n++; @(negedge clk); #1; end
        chk("R3 busy length", n, BUSYC);
        rd_chk(3'd4, 32'h2, "R4 ready after accept");
        rd_chk(3'd5, 32'hF0F0_1234, "R6 first program");
        rd_chk(3'd6, 32'd3, "R5 write-once keeps pointer");
        wr(3'd3, 32'h0F0F_FFFF); wr(3'd2, 32'h2); wait_idle();
        rd_chk(3'd5, 32'h0000_1234, "R6 program only clears bits");
        rd_chk(3'd4, 32'h2, "R10 two programs no error");
        wr(3'd3, 32'hFFFF_FFFF); wr(3'd2, 32'h2); wait_idle();
        rd_chk(3'd4, 32'h6, "R10 third program flags error");

        // R11: command while busy
        wr(3'd3, 32'h0); wr(3'd2, 32'h2); wr(3'd2, 32'h8); wait_idle();
        rd_chk(3'd4, 32'hE, "R11 busy command error");
        rd_chk(3'd5, 32'h0, "R11 erase during busy ignored");
        wr(3'd2, 32'h10);
        rd_chk(3'd4, 32'h2, "R12 clear errors");

        // R5: trigger with wrap
        wr(3'd1, 6); wr(3'd2, 32'h1);
        wr(3'd3, 32'h1111_AAAA); wr(3'd2, 32'h4); wait_idle();
        rd_chk(3'd6, 32'd7, "R5 trigger advances");
        wr(3'd3, 32'h2222_BBBB); wr(3'd2, 32'h4); wait_idle();
        rd_chk(3'd6, 32'd0, "R5 wrap to page start");
        wr(3'd3, 32'h3333_CCCC); wr(3'd2, 32'h4); wait_idle();
        rd_chk(3'd6, 32'd1, "R5 pointer after wrap");
        peek(6, 32'h1111_AAAA, "R5 word 6");
        peek(7, 32'h2222_BBBB, "R5 word 7");
        peek(0, 32'h3333_CCCC, "R5 wrapped word 0");

        // R7: erase page 0
        wr(3'd2, 32'h8); wait_idle();
        peek(3, 32'hFFFF_FFFF, "R7 erase word 3");
        peek(0, 32'hFFFF_FFFF, "R7 erase word 0");
        program_at(3, 32'h0);
        rd_chk(3'd4, 32'h2, "R7 erase resets program count");

        // R8: lock page 1
        program_at(LBASE, 32'hFFFF_FFFD);
        wr(3'd1, 9); wr(3'd2, 32'h1); wr(3'd3, 32'h0); wr(3'd2, 32'h2);
        rd_chk(3'd4, 32'h0, "R8 locked program dropped");
        rd_chk(3'd5, 32'hFFFF_FFFF, "R8 locked word unchanged");
        wr(3'd2, 32'h8);
        rd_chk(3'd4, 32'h0, "R8 locked erase dropped");

        // R9: lock page self protection and debug bypass
        program_at(LBASE, 32'hFFFF_FFEF);
        rd_chk(3'd5, 32'hFFFF_FFED, "R9 lock word programmed");
        wr(3'd2, 32'h8);
        rd_chk(3'd4, 32'h2, "R9 lock page erase refused");
        rd_chk(3'd5, 32'hFFFF_FFED, "R9 lock word kept");
        dbg_mode = 1'b1;
        wr(3'd2, 32'h8); wait_idle();
        rd_chk(3'd5, 32'hFFFF_FFFF, "R9 debug mode erase");
        dbg_mode = 1'b0;
        program_at(9, 32'h1234_5678);
        rd_chk(3'd5, 32'h1234_5678, "R8 page writable after unlock");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule